// File: doc/BRIEF.md
# Memory Pattern Test Engine

This block is a built-in self-test sequencer for a byte-wide RAM that sits behind a simple synchronous single-port interface. After a start pulse it takes over the memory port. It runs six test phases in a fixed order and then reports pass or fail. On a failure it also reports the first failing address, the byte it expected and the byte it read back.

The main coverage test is a March-C sweep. Five fill-then-verify phases follow it, each writing one data pattern:

- solid zeros;
- solid ones;
- a checkerboard;
- the inverse checkerboard;
- a byte chosen by the user.

Between the last write of each fill phase and its first read, the engine can stay idle for a programmable number of cycles. During that wait the cells must hold their data on their own, which exercises retention and refresh. The user byte and the wait length are captured when the start pulse is accepted.

Top module: `mtest_engine`

## Requirements
- R1: While reset is asserted and right after it is released, busy_o, done_o, fail_o and mem_req_o are low and phase_o is 0.
- R2: A start_i pulse accepted while idle or done clears done_o and fail_o and raises busy_o on the next cycle. At the end of the run busy_o falls and done_o rises. done_o and the failure fields stay unchanged until the next accepted start_i.
- R3: A start_i pulse while busy_o is high has no effect: the run continues, and the time from its start to done_o is unchanged.
- R4: Each memory access is a one-cycle mem_req_o with mem_we_o, mem_addr_o and mem_wdata_o. mem_rdata_i is sampled in the cycle after a read request, and that cycle carries no request.
- R5: phase_o shows the current phase, and phases run in the order 0 (March-C), 1 (zeros), 2 (ones), 3 (checkerboard), 4 (inverse checkerboard), 5 (user byte). Within a run, phase_o never decreases.
- R6: Phase 0 performs, in order, with N = 2^AW:
  1. write 0x00 to addresses 0..N-1 ascending;
  2. ascending, read 0x00 then write 0xFF at each address;
  3. ascending, read 0xFF then write 0x00;
  4. descending, read 0x00 then write 0xFF;
  5. descending, read 0xFF then write 0x00;
  6. read 0x00 ascending.
  
  That is 10N accesses in total.
- R7: Phases 1 to 5 each write their pattern to every address from 0 to N-1 in ascending order, then read and compare every address in ascending order. Phase 1 uses 0x00 and phase 2 uses 0xFF.
- R8: Phase 3 writes 0x55 at even addresses and 0xAA at odd addresses. Phase 4 writes 0xAA at even addresses and 0x55 at odd addresses.
- R9: Phase 5 uses the value of user_byte_i captured at start, so a passing run leaves every address holding that byte.
- R10: The start-captured ret_cycles_i value D inserts exactly D access-free cycles between the last write and the first read of each of phases 1 to 5, and none in phase 0. A run therefore lasts 5D cycles longer than with D = 0.
- R11: On the first read mismatch the engine stops issuing accesses and raises fail_o together with done_o. fail_addr_o, fail_exp_o and fail_got_o hold the address, the expected byte and the read byte, and phase_o holds the failing phase. A clean run ends with fail_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| user_byte_i | input | DW | Pattern for the user phase, captured at start |
| ret_cycles_i | input | TW | Retention wait in cycles, captured at start |
| busy_o | output | 1 | Test running |
| done_o | output | 1 | Run finished; held until the next start |
| fail_o | output | 1 | Run ended on a mismatch |
| phase_o | output | 3 | Current or last phase code |
| fail_addr_o | output | AW | First failing address |
| fail_exp_o | output | DW | Expected byte at the failure |
| fail_got_o | output | DW | Byte read at the failure |
| mem_req_o | output | 1 | Memory access request, one cycle |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read request |

## Verification
Most internal faults in the sequencer show up at the memory port within a single access. These include a wrong element index, a wrong address direction or a wrong pattern bit, and each one appears as a write of the wrong value or an access out of order. The bench compares every phase-0 access and every fill write against the stream the requirements define. A broken wait counter is visible only in the length of a run, so it is measured as the difference in cycles between runs that use different wait values. Faults injected into the bench memory at a chosen phase must be reported at the exact first address, with the exact bytes, before any further access is made.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

  typedef enum logic [2:0] {
    PH_MARCH = 3'd0,
    PH_ZERO  = 3'd1,
    PH_ONE   = 3'd2,
    PH_CHK   = 3'd3,
    PH_ICHK  = 3'd4,
    PH_USER  = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_RD,
    S_CHK,
    S_WAIT,
    S_DONE
  } state_e;

  // one march element: direction, read/write with background, wait-before, last in phase
  typedef struct packed {
    logic down;
    logic rd;
    logic rd_bg;
    logic wr;
    logic wr_bg;
    logic hold;
    logic last;
  } elem_t;

  function automatic elem_t elem_spec(phase_e ph, logic [2:0] el);
    elem_t e;
    e = '0;
    if (ph == PH_MARCH) begin
      case (el)
        3'd0: begin e.wr = 1'b1; e.wr_bg = 1'b0; end
        3'd1: begin e.rd = 1'b1; e.rd_bg = 1'b0; e.wr = 1'b1; e.wr_bg = 1'b1; end
        3'd2: begin e.rd = 1'b1; e.rd_bg = 1'b1; e.wr = 1'b1; e.wr_bg = 1'b0; end
        3'd3: begin e.down = 1'b1; e.rd = 1'b1; e.rd_bg = 1'b0; e.wr = 1'b1; e.wr_bg = 1'b1; end
        3'd4: begin e.down = 1'b1; e.rd = 1'b1; e.rd_bg = 1'b1; e.wr = 1'b1; e.wr_bg = 1'b0; end
        default: begin e.rd = 1'b1; e.rd_bg = 1'b0; e.last = 1'b1; end
      endcase
    end else if (el == 3'd0) begin
      e.wr = 1'b1;
    end else begin
      e.rd   = 1'b1;
      e.hold = 1'b1;
      e.last = 1'b1;
    end
    return e;
  endfunction

endpackage

// File: rtl/mtest_pattern.sv
module mtest_pattern
  import mtest_pkg::*;
#(
  parameter int DW = 8
) (
  input  phase_e          phase_i,
  input  logic            bg_i,
  input  logic            odd_i,
  input  logic [DW-1:0]   user_i,
  output logic [DW-1:0]   data_o
);

  localparam logic [DW-1:0] ALL0 = '0;
  localparam logic [DW-1:0] ALL1 = '1;

  logic [DW-1:0] chk_even;

  // alternating bits, LSB set: 0x55 for a byte
  generate
    for (genvar i = 0; i < DW; i++) begin : g_chk
      assign chk_even[i] = ~i[0];
    end
  endgenerate

  always_comb begin
    case (phase_i)
      PH_MARCH: data_o = bg_i ? ALL1 : ALL0;
      PH_ZERO:  data_o = ALL0;
      PH_ONE:   data_o = ALL1;
      PH_CHK:   data_o = odd_i ? ~chk_even : chk_even;
      PH_ICHK:  data_o = odd_i ? chk_even : ~chk_even;
      PH_USER:  data_o = user_i;
      default:  data_o = ALL0;
    endcase
  end

endmodule

// File: rtl/mtest_addr_ctr.sv
module mtest_addr_ctr #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          load_down_i,
  input  logic          step_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] AMAX = {AW{1'b1}};

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_down_i ? AMAX : '0;
    else if (step_i)  addr_q <= down_i ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = down_i ? (addr_q == '0) : (addr_q == AMAX);

  AST_ADDR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !down_i) |=> (addr_q == $past(addr_q) + 1'b1)); // R6
  AST_ADDR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && down_i) |=> (addr_q == $past(addr_q) - 1'b1)); // R6

endmodule

// File: rtl/mtest_ret_timer.sv
module mtest_ret_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          expire_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == TW'(1));

  AST_TMR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10

endmodule

// File: rtl/mtest_engine.sv
module mtest_engine
  import mtest_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] user_byte_i,
  input  logic [TW-1:0] ret_cycles_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [2:0]    phase_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [DW-1:0] fail_exp_o,
  output logic [DW-1:0] fail_got_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);

  state_e        state_q, state_d;
  phase_e        phase_q, phase_d, nx_ph;
  logic [2:0]    elem_q, elem_d, nx_el;
  logic [DW-1:0] user_q;
  logic [TW-1:0] dly_q;
  logic          fail_q;
  logic [AW-1:0] faddr_q;
  logic [DW-1:0] fexp_q, fgot_q;

  elem_t         cur, nxt;
  logic          fin, seq_end, mismatch, start_acc;
  logic          addr_load, load_down, addr_step, addr_last, tmr_load, tmr_exp;
  logic [AW-1:0] addr;
  logic [DW-1:0] exp_rd, dat_wr;

  assign cur = elem_spec(phase_q, elem_q);

  // successor element
  always_comb begin
    fin   = 1'b0;
    nx_ph = phase_q;
    nx_el = elem_q + 3'd1;
    if (cur.last) begin
      nx_el = 3'd0;
      if (phase_q == PH_USER) fin = 1'b1;
      else nx_ph = phase_e'(3'(phase_q + 3'd1));
    end
  end

  assign nxt = elem_spec(nx_ph, nx_el);

  mtest_addr_ctr #(.AW(AW)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (addr_load),
    .load_down_i (load_down),
    .step_i      (addr_step),
    .down_i      (cur.down),
    .addr_o      (addr),
    .last_o      (addr_last)
  );

  mtest_ret_timer #(.TW(TW)) i_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (dly_q),
    .expire_o (tmr_exp)
  );

  mtest_pattern #(.DW(DW)) i_pat_rd (
    .phase_i (phase_q),
    .bg_i    (cur.rd_bg),
    .odd_i   (addr[0]),
    .user_i  (user_q),
    .data_o  (exp_rd)
  );

  mtest_pattern #(.DW(DW)) i_pat_wr (
    .phase_i (phase_q),
    .bg_i    (cur.wr_bg),
    .odd_i   (addr[0]),
    .user_i  (user_q),
    .data_o  (dat_wr)
  );

  assign mismatch  = (mem_rdata_i != exp_rd);
  assign start_acc = start_i && (state_q == S_IDLE || state_q == S_DONE);

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    elem_d    = elem_q;
    addr_load = 1'b0;
    load_down = 1'b0;
    addr_step = 1'b0;
    tmr_load  = 1'b0;
    seq_end   = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    case (state_q)
      S_IDLE, S_DONE: begin
        if (start_i) begin
          state_d   = S_WR;
          phase_d   = PH_MARCH;
          elem_d    = 3'd0;
          addr_load = 1'b1;
        end
      end
      S_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        seq_end   = 1'b1;
      end
      S_RD: begin
        mem_req_o = 1'b1;
        state_d   = S_CHK;
      end
      S_CHK: begin
        if (mismatch)    state_d = S_DONE;
        else if (cur.wr) state_d = S_WR;
        else             seq_end = 1'b1;
      end
      S_WAIT: begin
        if (tmr_exp) state_d = S_RD;
      end
      default: state_d = S_IDLE;
    endcase

    if (seq_end) begin
      if (!addr_last) begin
        addr_step = 1'b1;
        state_d   = cur.rd ? S_RD : S_WR;
      end else if (fin) begin
        state_d = S_DONE;
      end else begin
        phase_d   = nx_ph;
        elem_d    = nx_el;
        addr_load = 1'b1;
        load_down = nxt.down;
        if (nxt.hold && dly_q != '0) begin
          state_d  = S_WAIT;
          tmr_load = 1'b1;
        end else begin
          state_d = nxt.rd ? S_RD : S_WR;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= PH_MARCH;
      elem_q  <= '0;
      user_q  <= '0;
      dly_q   <= '0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fgot_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      elem_q  <= elem_d;
      if (start_acc) begin
        user_q  <= user_byte_i;
        dly_q   <= ret_cycles_i;
        fail_q  <= 1'b0;
        faddr_q <= '0;
        fexp_q  <= '0;
        fgot_q  <= '0;
      end else if (state_q == S_CHK && mismatch) begin
        fail_q  <= 1'b1;
        faddr_q <= addr;
        fexp_q  <= exp_rd;
        fgot_q  <= mem_rdata_i;
      end
    end
  end

  assign busy_o      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o      = (state_q == S_DONE);
  assign fail_o      = fail_q;
  assign phase_o     = phase_q;
  assign fail_addr_o = faddr_q;
  assign fail_exp_o  = fexp_q;
  assign fail_got_o  = fgot_q;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = dat_wr;

  AST_FAIL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R11
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(fail_addr_o) && $stable(fail_got_o))); // R2
  AST_PHASE_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (phase_o >= $past(phase_o))); // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && phase_o != 3'd0) |=> (phase_o != 3'd0)); // R3
  AST_CHECK_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o); // R4

endmodule

// File: tb/test_mtest_engine.sv
module test_mtest_engine;

  localparam int AW = 6;
  localparam int N  = 1 << AW;
  localparam int DW = 8;
  localparam int TW = 12;
  localparam int MS = 10 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] user_b = '0;
  logic [TW-1:0] dly = '0;
  logic          busy, done, fail;
  logic [2:0]    phase;
  logic [AW-1:0] faddr, maddr;
  logic [DW-1:0] fexp, fgot, mwdata;
  logic [DW-1:0] mrdata = '0;
  logic          mreq, mwe;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mtest_engine #(.AW(AW), .DW(DW), .TW(TW)) i_mtest_engine (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .user_byte_i (user_b), .ret_cycles_i (dly),
    .busy_o (busy), .done_o (done), .fail_o (fail), .phase_o (phase),
    .fail_addr_o (faddr), .fail_exp_o (fexp), .fail_got_o (fgot),
    .mem_req_o (mreq), .mem_we_o (mwe), .mem_addr_o (maddr),
    .mem_wdata_o (mwdata), .mem_rdata_i (mrdata)
  );

  // memory model with phase-armed read fault and retention decay
  logic [DW-1:0] mem [N];
  int            wtime [N];
  int            cyc = 0;
  logic          flt_en = 1'b0;
  int            flt_ph = 0;
  int            flt_addr = 0;
  logic [DW-1:0] flt_mask = '0;
  logic          dec_en = 1'b0;
  int            dec_t = 400;

  always @(posedge clk) begin
    logic [DW-1:0] v;
    cyc <= cyc + 1;
    if (mreq && mwe) begin
      mem[maddr]   <= mwdata;
      wtime[maddr] <= cyc;
    end
    if (mreq && !mwe) begin
      v = mem[maddr];
      if (flt_en && busy && int'(phase) >= flt_ph && int'(maddr) == flt_addr) v = v ^ flt_mask;
      if (dec_en && (cyc - wtime[maddr]) > dec_t) v = '0;
      mrdata <= v;
    end
  end

  function automatic logic [DW-1:0] pat(int ph, int a, logic [DW-1:0] u);
    case (ph)
      1: return 8'h00;
      2: return 8'hFF;
      3: return a[0] ? 8'hAA : 8'h55;
      4: return a[0] ? 8'h55 : 8'hAA;
      5: return u;
      default: return 8'h00;
    endcase
  endfunction

  // expected phase-0 access stream
  logic          e_we [MS];
  int            e_ad [MS];
  logic [DW-1:0] e_wd [MS];

  initial begin
    int k;
    k = 0;
    for (int a = 0; a < N; a++) begin e_we[k] = 1; e_ad[k] = a; e_wd[k] = 8'h00; k++; end
    for (int el = 1; el <= 4; el++) begin
      for (int i = 0; i < N; i++) begin
        int a;
        a = (el >= 3) ? N - 1 - i : i;
        e_we[k] = 0; e_ad[k] = a; e_wd[k] = 8'h00; k++;
        e_we[k] = 1; e_ad[k] = a; e_wd[k] = (el == 1 || el == 3) ? 8'hFF : 8'h00; k++;
      end
    end
    for (int a = 0; a < N; a++) begin e_we[k] = 0; e_ad[k] = a; e_wd[k] = 8'h00; k++; end
  end

  // port monitors
  int ms_idx = 0, ms_tot = 0, ms_err = 0, wp_err = 0, ph_err = 0, proto_err = 0, quiet_err = 0;
  int ph_last = 0;
  logic prev_rd = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rd && mreq) proto_err <= proto_err + 1;
      prev_rd <= mreq && !mwe;
      if (!busy && mreq) quiet_err <= quiet_err + 1;
      if (!busy) begin
        ms_idx  <= 0;
        ph_last <= 0;
      end else begin
        if (mreq && phase == 3'd0) begin
          if (ms_idx < MS) begin
            if (mwe != e_we[ms_idx] || int'(maddr) != e_ad[ms_idx] || (mwe && mwdata != e_wd[ms_idx]))
              ms_err <= ms_err + 1;
          end else ms_err <= ms_err + 1;
          ms_idx <= ms_idx + 1;
          ms_tot <= ms_tot + 1;
        end
        if (mreq && mwe && phase != 3'd0 && mwdata != pat(int'(phase), int'(maddr), user_b))
          wp_err <= wp_err + 1;
        if (int'(phase) != ph_last) begin
          if (int'(phase) != ph_last + 1) ph_err <= ph_err + 1;
          ph_last <= int'(phase);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // user_b and dly stay on the pins for the whole run (write monitor uses user_b)
  task automatic run(logic [DW-1:0] u, int d, int spur, output int cycles);
    @(negedge clk);
    user_b = u;
    dly = TW'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 50000) begin
      @(negedge clk);
      cycles++;
      start = (cycles == spur || cycles == spur + 1400);
    end
    start = 1'b0;
    if (cycles >= 50000) check(0, "watchdog", cycles, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    $display("FAIL watchdog: run hung");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int c0, c1, c2, e0, e1, e2, e3, e4, e5;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !mreq && phase == 3'd0, "R1 reset", {busy, done, fail, mreq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fail && !mreq && phase == 3'd0, "R1 after release", {busy, done, fail, mreq}, 0);

    // clean run
    e0 = ms_tot; e1 = ms_err; e2 = wp_err; e3 = ph_err; e4 = proto_err;
    run(8'h3C, 0, -5, c0);
    check(done && !busy, "R2 done at end", {done, busy}, 2);
    check(!fail, "R11 clean run passes", fail, 0);
    check(ms_tot - e0 == MS, "R6 access count", ms_tot - e0, MS);
    check(ms_err == e1, "R6 access order", ms_err - e1, 0);
    check(wp_err == e2, "R7 R8 fill patterns", wp_err - e2, 0);
    check(ph_err == e3 && phase == 3'd5, "R5 phase order", int'(phase), 5);
    check(proto_err == e4, "R4 compare slot free", proto_err - e4, 0);
    e5 = 0;
    for (int a = 0; a < N; a++) if (mem[a] != 8'h3C) e5++;
    check(e5 == 0, "R9 user byte left", e5, 0);
    repeat (20) @(negedge clk);
    check(done && !busy && !fail, "R2 done held", done, 1);

    // retention wait length
    run(8'hA7, 7, -5, c1);
    check(c1 - c0 == 35, "R10 wait adds 5D", c1 - c0, 35);
    run(8'h01, 0, -5, c2);
    check(c2 == c0, "R10 zero wait", c2, c0);

    // start pulses during the run
    run(8'h3C, 0, 100, c2);
    check(c2 == c0 && !fail, "R3 start ignored while busy", c2, c0);

    // retention fault
    dec_en = 1'b1;
    run(8'h12, 0, -5, c2);
    check(!fail, "R10 short gap retains", fail, 0);
    run(8'h12, 500, -5, c2);
    check(fail && phase == 3'd2 && faddr == 0 && fexp == 8'hFF && fgot == 8'h00,
          "R10 R11 decay seen in ones phase", {int'(phase), int'(faddr), int'(fgot)}, 'h20000);
    dec_en = 1'b0;

    // random read faults armed at a chosen phase
    for (int it = 0; it < 14; it++) begin
      int k, a;
      logic [DW-1:0] m, u, ex;
      k = (it < 6) ? it : int'($urandom % 6);
      a = (it == 6) ? N - 1 : int'($urandom % N);
      m = DW'($urandom % 255 + 1);
      u = DW'($urandom);
      flt_ph = k; flt_addr = a; flt_mask = m; flt_en = 1'b1;
      e0 = quiet_err;
      run(u, int'($urandom % 5), -5, c2);
      ex = (k == 0) ? 8'h00 : pat(k, a, u);
      check(done && fail, "R11 fault flagged", fail, 1);
      check(int'(phase) == k && int'(faddr) == a, "R11 fault location",
            int'(phase) * 256 + int'(faddr), k * 256 + a);
      check(fexp == ex && fgot == (ex ^ m), "R11 fault bytes", {fexp, fgot}, {ex, ex ^ m});
      repeat (5) @(negedge clk);
      check(quiet_err == e0 && done && fail && int'(faddr) == a, "R2 R11 stopped and held",
            quiet_err - e0, 0);
      flt_en = 1'b0;
    end

    // new start clears the failure
    run(8'h5A, 2, -5, c2);
    check(done && !fail, "R2 restart clears fail", fail, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule